// File: doc/BRIEF.md
# Line-Code Violation Tally with Snapshot Register

This block keeps a running tally of line-code violations reported by a receive decoder. It adds one for every clock in which the violation strobe is high. The tally never wraps: once every bit is set, it stays there. The counter has no enable and runs from reset onward.

A host takes a reading by writing a 0 and then a 1 to a single control bit. On the clock where the bit is first seen high, the current tally moves into a snapshot register and the tally starts again. The bit must go back to 0 before another snapshot can be taken. A violation that arrives in the same clock as the snapshot is not lost: the fresh tally starts at one. The snapshot appears as a full word and also as an upper half and a lower half, for a host with a narrow bus.

Top module: `lcv_tally`

## Requirements
- R1: After reset, the snapshot output (`held_count`, `held_hi` and `held_lo`) is 0, the internal tally is 0, and the stored previous value of `update_bit` is 0.
- R2: On the first clock edge at which `update_bit` is sampled at 1 after being 0, `held_count` takes the tally value from before that clock. A violation strobe in the same clock is not added to this snapshot.
- R3: When `update_bit` stays at 1 over further clock edges, no further snapshot is taken. A new snapshot needs `update_bit` to be sampled at 0 and then at 1.
- R4: When the violation strobe is high on the snapshot clock, the tally restarts at 1. The next snapshot then includes that strobe.
- R5: The tally stops at the all-ones value (255 for `CNT_W`=8, 65535 for 16) and never wraps to 0.
- R6: The tally rises by exactly one for each clock edge at which `lcv_pulse` is sampled high, with no enable condition.
- R7: `held_hi` equals bits [`CNT_W`-1 : `CNT_W`/2] of `held_count`, and `held_lo` equals bits [`CNT_W`/2-1 : 0].
- R8: `held_count` keeps its value on every clock that is not a snapshot clock.
- R9: On a snapshot clock with `lcv_pulse` low, the tally restarts at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lcv_pulse | input | 1 | Violation strobe; adds one per clock while high |
| update_bit | input | 1 | Host snapshot control bit; acts on its rising change |
| held_count | output | CNT_W | Snapshot of the tally |
| held_hi | output | CNT_W/2 | Upper half of the snapshot |
| held_lo | output | CNT_W/2 | Lower half of the snapshot |

## Verification
The bench builds the block with `CNT_W` = 8. At that width, saturation is reached after a few hundred strobes, so the no-wrap ceiling is driven well past its limit within a short run. The narrower halves of 4 bits each make a split error at the half boundary show up in ordinary tally values. The same RTL at the default width of 16 differs only in the width parameter.

// File: rtl/lcv_tally_pkg.sv
package lcv_tally_pkg;

    localparam int unsigned DEFAULT_CNT_W = 16;

    typedef struct packed {
        logic prev;
    } rise_state_t;

endpackage

// File: rtl/lcv_rise_detect.sv
module lcv_rise_detect
    import lcv_tally_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    output logic fire
);

    rise_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = level_in;
        fire      = level_in & ~st_q.prev;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire); // R3

    AST_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (level_in && $past(level_in)) |-> !fire); // R3

endmodule

// File: rtl/lcv_sat_counter.sv
module lcv_sat_counter #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         restart,
    output logic [W-1:0] count
);

    localparam logic [W-1:0] TOP = '1;
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (restart) begin
            st_d.cnt = inc ? ONE : '0;
        end else if (inc && (st_q.cnt != TOP)) begin
            st_d.cnt = st_q.cnt + ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.cnt;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (count == TOP && !restart) |=> count == TOP); // R5

    AST_PRESET_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && inc) |=> count == ONE); // R4

    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && !inc) |=> count == '0); // R9

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && inc && count != TOP) |=> count == $past(count) + ONE); // R6

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && !inc) |=> $stable(count)); // R6

endmodule

// File: rtl/lcv_hold_reg.sv
module lcv_hold_reg #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    typedef struct packed {
        logic [W-1:0] val;
    } hold_state_t;

    hold_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) st_d.val = din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.val;

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(dout)); // R8

    AST_HOLD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> dout == $past(din)); // R2

endmodule

// File: rtl/lcv_tally.sv
module lcv_tally
    import lcv_tally_pkg::*;
#(
    parameter int unsigned CNT_W = DEFAULT_CNT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lcv_pulse,
    input  logic               update_bit,
    output logic [CNT_W-1:0]   held_count,
    output logic [CNT_W/2-1:0] held_hi,
    output logic [CNT_W/2-1:0] held_lo
);

    localparam int unsigned HALF_W = CNT_W / 2;

    logic             snap_fire;
    logic [CNT_W-1:0] tally;

    lcv_rise_detect u_rise (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_in (update_bit),
        .fire     (snap_fire)
    );

    lcv_sat_counter #(.W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (lcv_pulse),
        .restart (snap_fire),
        .count   (tally)
    );

    lcv_hold_reg #(.W(CNT_W)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (snap_fire),
        .din   (tally),
        .dout  (held_count)
    );

    assign held_hi = held_count[CNT_W-1 -: HALF_W];
    assign held_lo = held_count[HALF_W-1:0];

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (held_count == '0 && tally == '0)); // R1

    AST_SNAP_PRE_INC: assert property (@(posedge clk) disable iff (!rst_n)
        snap_fire |=> held_count == $past(tally)); // R2

endmodule

// File: tb/tb_lcv_tally.sv
module tb_lcv_tally;

    localparam int unsigned W    = 8;
    localparam int unsigned H    = W / 2;
    localparam logic [W-1:0] TOP = '1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         lcv_pulse = 1'b0;
    logic         update_bit = 1'b0;
    logic [W-1:0] held_count;
    logic [H-1:0] held_hi, held_lo;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [W-1:0] exp_q[$];
    logic [W-1:0] m_cnt  = '0;
    logic         m_prev = 1'b0;
    logic [W-1:0] m_held = '0;

    always #10 clk = ~clk;

    lcv_tally #(.CNT_W(W)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .lcv_pulse  (lcv_pulse),
        .update_bit (update_bit),
        .held_count (held_count),
        .held_hi    (held_hi),
        .held_lo    (held_lo)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Driver: applies one clock of stimulus and updates the reference model.
    task automatic drive(input logic lcv, input logic upd);
        @(negedge clk);
        lcv_pulse  = lcv;
        update_bit = upd;
        if (upd && !m_prev) begin
            exp_q.push_back(m_cnt);          // R2: value before this clock's strobe
            m_cnt = lcv ? 1 : 0;             // R4 / R9
        end else if (lcv && m_cnt != TOP) begin
            m_cnt = m_cnt + 1'b1;            // R6, saturating R5
        end
        m_prev = upd;
    endtask

    // Monitor: samples after each rising edge.
    always @(posedge clk) begin
        #2;
        if (rst_n && !done) begin
            if (exp_q.size() > 0) begin
                m_held = exp_q.pop_front();
                check("R2", held_count, m_held);
                check("R7", {{(W-H){1'b0}}, held_hi}, {{(W-H){1'b0}}, m_held[W-1 -: H]});
                check("R7", {{(W-H){1'b0}}, held_lo}, {{(W-H){1'b0}}, m_held[H-1:0]});
            end else begin
                check("R8", held_count, m_held);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1", held_count, '0);
        check("R1", {{(W-H){1'b0}}, held_hi}, '0);

        // R6: ten strobes, then a snapshot (expect 10)
        repeat (10) drive(1'b1, 1'b0);
        drive(1'b0, 1'b1);
        drive(1'b0, 1'b0);
        // R9: snapshot right away with no strobes (expect 0)
        drive(1'b0, 1'b1);
        drive(1'b0, 1'b0);

        // R3: bit held high with strobes arriving, no extra snapshot
        drive(1'b0, 1'b1);                  // snapshot of 0
        repeat (5) drive(1'b1, 1'b1);       // counts, no snapshot
        drive(1'b0, 1'b0);
        drive(1'b0, 1'b1);                  // expect 5
        drive(1'b0, 1'b0);

        // R4: strobe on the snapshot clock
        repeat (3) drive(1'b1, 1'b0);
        drive(1'b1, 1'b1);                  // expect 3, restart at 1
        drive(1'b0, 1'b0);
        drive(1'b0, 1'b1);                  // expect 1
        drive(1'b0, 1'b0);

        // Alternating strobes, spread across the half boundary (R7)
        for (int i = 0; i < 46; i++) drive(i[0], 1'b0);
        drive(1'b0, 1'b1);                  // expect 23
        drive(1'b0, 1'b0);

        // R5: far past the ceiling
        repeat (300) drive(1'b1, 1'b0);
        drive(1'b0, 1'b1);                  // expect 255
        drive(1'b0, 1'b0);
        repeat (2) drive(1'b1, 1'b0);
        drive(1'b0, 1'b1);                  // expect 2: restarted, no stale ceiling
        repeat (4) drive(1'b0, 1'b0);

        // R1: reset again in the middle of a tally
        repeat (7) drive(1'b1, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        lcv_pulse = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_cnt = '0; m_prev = 1'b0; m_held = '0;
        exp_q.delete();
        #1;
        check("R1", held_count, '0);
        drive(1'b0, 1'b1);                  // expect 0: tally was cleared by reset
        repeat (3) drive(1'b0, 1'b0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule